// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A single-port synchronous memory for a processor cache. It has a registered address path and a built-in two-bit burst counter. The data word is 18 bits wide, made of two 9-bit lanes, and each lane has its own write enable.

Either of two address strobes opens a burst: one comes from the processor and one from the cache controller. The captured address is the first beat. An advance input then steps the two low address bits through a four-beat sequence. A parameter selects whether that sequence is interleaved (XOR) or linear (modulo-4 increment). The upper address bits stay fixed for the whole burst.

Writes are synchronous and self-timed, and each write lands on the edge where it is presented. A controller-initiated start may carry a write to the captured address. Read data for the current burst address appears one clock after that address is captured or advanced. It is driven on a plain output bus together with a drive-enable flag. The drive-enable is gated at once, without waiting for a clock, by the output enable.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset, `dout_en` is low and no burst is open until a qualified strobe arrives.
- R2: On an edge with `cs` high and `adsp` or `adsc` high, `addr` is captured as the burst start. One clock later `dout` shows the word at that address and `dout_en` is high (with `oe` high).
- R3: A strobe on an edge with `cs` low is ignored: no address is captured and no burst opens.
- R4: With `ORDER` set to interleaved, the low two address bits on successive advances are start XOR 0, 1, 2, 3, and then the sequence repeats.
- R5: With `ORDER` set to linear, the low two address bits on successive advances are start + 0, 1, 2, 3 modulo 4, and then the sequence repeats.
- R6: On an edge with `adv` low and no strobe, the burst address is held and `dout` repeats the same word.
- R7: During a burst, `addr` bits above bit 1 keep their captured value, so four advances return to the start word.
- R8: `wr_lane[0]` writes `din[8:0]` and `wr_lane[1]` writes `din[17:9]`, independently. Inside an open burst, a write goes to the current burst address on that edge, and an advance on the same edge takes effect after the write. A lane that is not enabled keeps its contents.
- R9: When both strobes are high on the same edge, the processor strobe wins. The start is a read and `wr_lane` is ignored on that edge. A start by `adsc` alone writes the enabled lanes of `din` to `addr`.
- R10: `oe` low forces `dout_en` low at once, without waiting for a clock edge.
- R11: An edge with `cs` low and no qualified strobe closes the burst. `dout_en` falls one clock later, and `wr_lane` has no effect while no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Synchronous chip select |
| adsp | input | 1 | Processor address strobe (priority, read start) |
| adsc | input | 1 | Controller address strobe (may start with a write) |
| adv | input | 1 | Burst advance |
| addr | input | ADDR_W | Word address |
| wr_lane | input | LANES | Per-lane write enables, bit 0 is the low lane |
| din | input | LANES*LANE_W | Write data |
| oe | input | 1 | Asynchronous output enable |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Read data valid / drive enable |

## Verification
The assertions assume that `rst` is held for at least one edge before use. They also assume that `addr`, the strobes and `adv` are known and stable around each rising edge. The address-hold and upper-bit properties apply only on edges where `cs` is high and no strobe is present. The stimulus changes every input on the falling edge, so the assertions always see settled values. It fills the whole array through controller-start writes before any reads, so no compared word is unknown. The only mid-cycle input change is the `oe` pulse of the directed case, which stays away from the rising edge.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low two address bits for beat number `beat` of a burst that began at `origin`.
  function automatic logic [1:0] beat_low(input logic [1:0] origin,
                                          input logic [1:0] beat,
                                          input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORDER_INTERLEAVED) r = origin ^ beat;
    else                          r = origin + beat;
    return r;
  endfunction

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W = 8,
  parameter burst_order_e ORDER  = ORDER_INTERLEAVED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              adsp,
  input  logic              adsc,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  output logic              open_q,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              start,
  output logic              start_wr_ok
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] origin_q;
  logic [1:0]        beat_q;

  assign start       = cs & (adsp | adsc);
  assign start_wr_ok = start & ~adsp;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      origin_q <= '0;
      beat_q   <= '0;
    end else if (start) begin
      open_q   <= 1'b1;
      origin_q <= addr;
      beat_q   <= '0;
    end else if (!cs) begin
      open_q   <= 1'b0;
    end else if (open_q && adv) begin
      beat_q   <= beat_q + 2'd1;
    end
  end

  assign beat_addr = {origin_q[ADDR_W-1 -: HI_W], beat_low(origin_q[1:0], beat_q, ORDER)};

endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];

  // Read-first single clock array, suited to block RAM inference.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W = 8,
  parameter int           LANE_W = 9,
  parameter int           LANES  = 2,
  parameter burst_order_e ORDER  = ORDER_INTERLEAVED
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    adsp,
  input  logic                    adsc,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int WORD_W = LANES * LANE_W;

  logic              act;
  logic [ADDR_W-1:0] cur_addr;
  logic              start;
  logic              start_wr_ok;
  logic              beat_wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic              vld_q;

  burst_addr_ctrl #(
    .ADDR_W (ADDR_W),
    .ORDER  (ORDER)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .adsp        (adsp),
    .adsc        (adsc),
    .adv         (adv),
    .addr        (addr),
    .open_q      (act),
    .beat_addr   (cur_addr),
    .start       (start),
    .start_wr_ok (start_wr_ok)
  );

  assign beat_wr_ok = cs & act & ~start;
  assign wr_addr    = start ? addr : cur_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    burst_sram_lane #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk   (clk),
      .we    (wr_lane[g] & (start_wr_ok | beat_wr_ok)),
      .waddr (wr_addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .raddr (cur_addr),
      .rdata (dout[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= act;
  end

  assign dout_en = vld_q & oe;

  logic unused_w;
  assign unused_w = ^WORD_W;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              adsp,
  input logic              adsc,
  input logic              adv,
  input logic              oe,
  input logic [ADDR_W-1:0] addr,
  input logic              dout_en,
  input logic              act,
  input logic [ADDR_W-1:0] cur_addr
);

  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && (adsp || adsc)) |=> (act && cur_addr == $past(addr)));

  // R3
  deselect_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs && (adsp || adsc)) |=> !act);

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cs && !adsp && !adsc && !adv) |=> $stable(cur_addr));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cs && !adsp && !adsc) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout_en);

  // R11
  close_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs && !act) |=> !dout_en);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs       (cs),
  .adsp     (adsp),
  .adsc     (adsc),
  .adv      (adv),
  .oe       (oe),
  .addr     (addr),
  .dout_en  (dout_en),
  .act      (act),
  .cur_addr (cur_addr)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  import burst_sram_pkg::*;

  localparam int AW    = 8;
  localparam int LW    = 9;
  localparam int NL    = 2;
  localparam int DW    = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, adsp = 1'b0, adsc = 1'b0, adv = 1'b0, oe = 1'b1;
  logic [NL-1:0] wr = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout_i, dout_l;
  logic          en_i, en_l;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .ORDER(ORDER_INTERLEAVED)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .adsp(adsp), .adsc(adsc), .adv(adv), .addr(addr),
    .wr_lane(wr), .din(din), .oe(oe), .dout(dout_i), .dout_en(en_i));

  burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .ORDER(ORDER_LINEAR)) u_dut_lin (
    .clk(clk), .rst(rst), .cs(cs), .adsp(adsp), .adsc(adsc), .adv(adv), .addr(addr),
    .wr_lane(wr), .din(din), .oe(oe), .dout(dout_l), .dout_en(en_l));

  int checks = 0;
  int fails  = 0;

  // Reference model: index 1 = interleaved, index 0 = linear
  logic [DW-1:0] mm [2][DEPTH];
  logic [AW-1:0] m_base [2];
  logic [1:0]    m_beat [2];
  logic          m_act  [2];
  logic          x_en   [2];
  logic [DW-1:0] x_d    [2];
  string         pend = "";

  function automatic logic [AW-1:0] m_cur(int m);
    logic [1:0] lo;
    lo = (m == 1) ? (m_base[m][1:0] ^ m_beat[m]) : (m_base[m][1:0] + m_beat[m]);
    return {m_base[m][AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] lane_mix(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] w);
    logic [DW-1:0] r;
    r = old;
    for (int k = 0; k < NL; k++) if (w[k]) r[k*LW +: LW] = nw[k*LW +: LW];
    return r;
  endfunction

  task automatic note(string tag, logic ok, logic [DW-1:0] got, logic [DW-1:0] exp, logic ge, logic xe);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h", tag, ge, got, xe, exp);
    end
  endtask

  task automatic compare_all();
    if (pend == "") return;
    for (int m = 0; m < 2; m++) begin
      logic          ge;
      logic [DW-1:0] gd;
      string         t;
      ge = (m == 1) ? en_i : en_l;
      gd = (m == 1) ? dout_i : dout_l;
      t  = (pend == "ADV") ? ((m == 1) ? "R4" : "R5") : pend;
      note(t, (ge === x_en[m]) && (!x_en[m] || gd === x_d[m]), gd, x_d[m], ge, x_en[m]);
    end
  endtask

  task automatic cyc(input logic c, input logic p, input logic s, input logic a,
                     input logic [NL-1:0] w, input logic [AW-1:0] ad,
                     input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    compare_all();
    cs = c; adsp = p; adsc = s; adv = a; wr = w; addr = ad; din = d;
    for (int m = 0; m < 2; m++) begin
      x_en[m] = m_act[m];
      x_d[m]  = mm[m][m_cur(m)];
      if (c && (p || s)) begin
        if (!p) mm[m][ad] = lane_mix(mm[m][ad], d, w);
        m_base[m] = ad; m_beat[m] = 2'd0; m_act[m] = 1'b1;
      end else if (!c) begin
        m_act[m] = 1'b0;
      end else if (m_act[m]) begin
        mm[m][m_cur(m)] = lane_mix(mm[m][m_cur(m)], d, w);
        if (a) m_beat[m] = m_beat[m] + 2'd1;
      end
    end
    pend = tag;
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 1237 + 91);
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    for (int m = 0; m < 2; m++) begin
      m_act[m] = 1'b0; m_base[m] = '0; m_beat[m] = '0; x_en[m] = 1'b0; x_d[m] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset leaves no burst open
    note("R1", en_i === 1'b0, dout_i, dout_i, en_i, 1'b0);
    note("R1", en_l === 1'b0, dout_l, dout_l, en_l, 1'b0);

    // Fill the array through controller-start writes (R9: adsc alone writes)
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 0, 2'b11, AW'(i), pat(i), "R9");

    // R2 then R4/R5 order and R7 wrap from start with low bits 2
    cyc(1, 1, 0, 0, 2'b00, 8'h26, '0, "R2");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R2");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "ADV");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "ADV");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R7");
    // R6 hold
    cyc(1, 0, 0, 0, 2'b00, 8'hff, '0, "R6");
    cyc(1, 0, 0, 0, 2'b00, 8'h11, '0, "R6");
    // R10: oe low gates the drive flag mid-cycle
    #1 oe = 1'b0;
    #0.5;
    note("R10", en_i === 1'b0, dout_i, dout_i, en_i, 1'b0);
    note("R10", en_l === 1'b0, dout_l, dout_l, en_l, 1'b0);
    oe = 1'b1;
    // R3: strobe under deselect ignored; R11 closes burst and blocks writes
    cyc(0, 1, 0, 0, 2'b11, 8'h50, 18'h3ffff, "R11");
    cyc(1, 0, 0, 0, 2'b11, 8'h50, 18'h3ffff, "R3");
    cyc(1, 0, 0, 0, 2'b00, 8'h50, '0, "R3");
    cyc(1, 0, 1, 0, 2'b00, 8'h50, '0, "R11");
    cyc(1, 0, 0, 0, 2'b00, 8'h00, '0, "R11");
    // R9: both strobes -> read start, write ignored
    cyc(1, 1, 1, 0, 2'b11, 8'h31, 18'h2aaaa, "R9");
    cyc(1, 0, 0, 0, 2'b00, 8'h00, '0, "R9");
    cyc(1, 0, 0, 0, 2'b00, 8'h00, '0, "R9");
    // R8: single-lane writes at start and inside a burst with advance
    cyc(1, 0, 1, 0, 2'b01, 8'h40, 18'h15555, "R8");
    cyc(1, 0, 0, 1, 2'b10, 8'h00, 18'h0f0f0, "R8");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R8");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R8");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R8");
    cyc(1, 0, 0, 1, 2'b00, 8'h00, '0, "R8");
    cyc(1, 0, 0, 0, 2'b00, 8'h00, '0, "R8");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic c, p, s, a;
      logic [NL-1:0] w;
      string t;
      c = ($urandom_range(0, 9) != 0);
      p = ($urandom_range(0, 9) == 0);
      s = ($urandom_range(0, 9) == 0);
      a = $urandom_range(0, 1) == 1;
      w = ($urandom_range(0, 4) == 0) ? NL'($urandom_range(1, 3)) : '0;
      if (c && (p || s))  t = p ? "R2" : "R9";
      else if (!c)        t = (p || s) ? "R3" : "R11";
      else if (w != 0)    t = "R8";
      else if (a)         t = "ADV";
      else                t = "R6";
      cyc(c, p, s, a, w, AW'($urandom), DW'($urandom), t);
    end
    cyc(1, 0, 0, 0, 2'b00, 8'h00, '0, "R6");
    @(negedge clk);
    compare_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule